// File: doc/BRIEF.md
# RC Oscillator Calibration Gate Controller

This block measures a slow, free-running standby clock against the fast main clock. Software holds a small 8-bit control/status register. Three of its bits set the frequency code for the RC oscillator. One bit routes a measurement gate to a timer's input. One bit starts a measurement. A sticky flag reports that the measurement has ended. The oscillator itself and the timer that counts during the gate sit outside this block.

When software starts a measurement, the block first brings the asynchronous standby clock into the main-clock domain. It then raises `gate` for exactly one standby period, from one synchronized rising edge of the standby clock to the next. While `gate` is high, an external timer counts main-clock pulses. The count gives the standby frequency, which software trims through the frequency code. The code maps linearly to an oscillator frequency of 44 kHz − 4 kHz × code, so code 0 is 44 kHz and code 7 is 16 kHz.

In test mode, when the external test pin is high and the routing bit is set, the block asks for the oscillator to be stopped.

Top module: `rc_cal_gate`

## Requirements
- R1: After reset the register reads 0x00, `gate`, `timerSelGate` and `oscStopReq` are 0, and `fcCode` is 000 (the 44 kHz setting).
- R2: A write stores `wrData[2:0]` as the frequency code, bit 3 as the routing bit and bit 4 as the start bit. All three read back at the same positions. Bits 5 and 6 always read as zero.
- R3: `fcCode` equals the stored register bits 2:0, and `timerSelGate` equals the stored bit 3.
- R4: `oscStopReq` is high exactly when `testPin` is high and stored bit 3 is set.
- R5: A 0-to-1 change of the start bit (bit 4) produces one `gate` pulse. The pulse begins after the next synchronized standby rising edge and ends after the following one, so its width is one standby period, within one main-clock cycle.
- R6: The completion flag (read at bit 7) becomes 1 in the same cycle that `gate` falls.
- R7: While the stored start bit is 1, a write with bit 7 = 0 leaves the completion flag set. This also applies to a write that clears the start bit in that same cycle.
- R8: The completion flag becomes set only when `gate` falls. Writing 1 to bit 7 never sets it. A write with bit 7 = 0 clears it only when the stored start bit is already 0.
- R9: No further `gate` pulse occurs while the start bit stays 1, including when 1 is rewritten to it. Clearing the bit and then setting it again starts a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data |
| sbClk | input | 1 | Asynchronous standby oscillator clock |
| testPin | input | 1 | External test-mode pin |
| gate | output | 1 | Measurement gate, one standby period wide |
| timerSelGate | output | 1 | Routes the gate to the timer input in place of its normal input |
| fcCode | output | 3 | Oscillator frequency code |
| oscStopReq | output | 1 | Request to stop the RC oscillator in test mode |

## Verification
The assertions assume that `sbClk` runs, and that its period spans several main-clock cycles. With that spacing the synchronizer delivers distinct rising edges, and the gate rise and fall stay ordered. The assertions also assume that register writes are single-cycle strobes. The stimulus keeps to these assumptions. It drives the standby clock at a fixed, unrelated period of 300 ns, about 37.5 main cycles. It applies every write as a one-cycle strobe away from the clock edge. It never toggles the start bit faster than a full measurement can complete.

// File: rtl/rc_cal_gate_pkg.sv
package rc_cal_gate_pkg;
  localparam int REG_W     = 8;
  localparam int FC_W      = 3;
  localparam int BIT_TEST  = 3;
  localparam int BIT_START = 4;
  localparam int BIT_DONE  = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_GATE = 2'd2
  } gateStateT;

  typedef struct packed {
    logic setReady;
    logic gateLevel;
  } ctlStrobeT;
endpackage

// File: rtl/rc_cal_gate_dp.sv
module rc_cal_gate_dp
  import rc_cal_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             sbClk,
  input  ctlStrobeT        strobes,
  output logic [REG_W-1:0] rdData,
  output logic [FC_W-1:0]  fcQ,
  output logic             testQ,
  output logic             countRise,
  output logic             sbRise
);
  localparam int PAD_W = BIT_DONE - BIT_START - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   sbPrev;
  logic                   countQ;
  logic                   countPrev;
  logic                   readyQ;
  logic                   clearReq;
  logic [PAD_W-1:0]       unusedWrBits;

  assign unusedWrBits = wrData[BIT_DONE-1:BIT_START+1];

  // Standby clock synchronizer, one flop per stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= sbClk;
  end

  genvar gi;
  generate
    for (gi = 1; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[gi] <= 1'b0;
        else       syncQ[gi] <= syncQ[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sbPrev <= 1'b0;
    else       sbPrev <= syncQ[SYNC_STAGES-1];
  end

  assign sbRise = syncQ[SYNC_STAGES-1] & ~sbPrev;

  // Control fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fcQ    <= '0;
      testQ  <= 1'b0;
      countQ <= 1'b0;
    end else if (wrEn) begin
      fcQ    <= wrData[FC_W-1:0];
      testQ  <= wrData[BIT_TEST];
      countQ <= wrData[BIT_START];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countPrev <= 1'b0;
    else       countPrev <= countQ;
  end

  assign countRise = countQ & ~countPrev;

  // Sticky completion flag; software clear blocked while start bit held
  assign clearReq = wrEn & ~wrData[BIT_DONE] & ~countQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 readyQ <= 1'b0;
    else if (strobes.setReady) readyQ <= 1'b1;
    else if (clearReq)         readyQ <= 1'b0;
  end

  assign rdData = {readyQ, {PAD_W{1'b0}}, countQ, testQ, fcQ};

  AST_READY_AT_GATE_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobes.gateLevel) |-> readyQ); // R6

  AST_READY_HELD_WHILE_START: assert property (@(posedge clk) disable iff (!rstN)
    ($past(readyQ) && $past(countQ)) |-> readyQ); // R7

  AST_READY_ONLY_FROM_GATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyQ) |-> $fell(strobes.gateLevel)); // R8
endmodule

// File: rtl/rc_cal_gate_ctrl.sv
module rc_cal_gate_ctrl
  import rc_cal_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      countRise,
  input  logic      sbRise,
  output ctlStrobeT strobes
);
  gateStateT stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobes.setReady = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (countRise) stateD = ST_ARM;
      ST_ARM:  if (sbRise)    stateD = ST_GATE;
      ST_GATE: if (sbRise) begin
        stateD = ST_IDLE;
        strobes.setReady = 1'b1;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign strobes.gateLevel = (stateQ == ST_GATE);

  AST_GATE_RISE_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.gateLevel) |-> $past(sbRise)); // R5

  AST_GATE_FALL_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobes.gateLevel) |-> $past(sbRise)); // R5
endmodule

// File: rtl/rc_cal_gate.sv
module rc_cal_gate
  import rc_cal_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             sbClk,
  input  logic             testPin,
  output logic             gate,
  output logic             timerSelGate,
  output logic [FC_W-1:0]  fcCode,
  output logic             oscStopReq
);
  ctlStrobeT strobes;
  logic      countRise;
  logic      sbRise;
  logic      testQ;

  rc_cal_gate_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrData    (wrData),
    .sbClk     (sbClk),
    .strobes   (strobes),
    .rdData    (rdData),
    .fcQ       (fcCode),
    .testQ     (testQ),
    .countRise (countRise),
    .sbRise    (sbRise)
  );

  rc_cal_gate_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .countRise (countRise),
    .sbRise    (sbRise),
    .strobes   (strobes)
  );

  assign gate         = strobes.gateLevel;
  assign timerSelGate = testQ;
  assign oscStopReq   = testPin & testQ;

  AST_STOP_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rstN)
    oscStopReq |-> (testPin && rdData[BIT_TEST])); // R4
endmodule

// File: tb/rc_cal_gate_tb.sv
module rc_cal_gate_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       sbClk = 1'b0;
  logic       testPin = 1'b0;
  logic       gate;
  logic       timerSelGate;
  logic [2:0] fcCode;
  logic       oscStopReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;
  always #150 sbClk = ~sbClk;

  rc_cal_gate u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .sbClk(sbClk), .testPin(testPin), .gate(gate), .timerSelGate(timerSelGate),
    .fcCode(fcCode), .oscStopReq(oscStopReq)
  );

  // {write value, expected readback}
  localparam logic [15:0] VEC [8] = '{
    {8'h07, 8'h07}, {8'hE5, 8'h05}, {8'h0B, 8'h0B}, {8'h6F, 8'h0F},
    {8'h02, 8'h02}, {8'h66, 8'h06}, {8'h08, 8'h08}, {8'h00, 8'h00}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // waits for a gate pulse; returns width in cycles, 0 if none within limit
  task automatic measure(input int limit, output int width, output bit readyAtFall);
    width = 0;
    readyAtFall = 1'b0;
    for (int i = 0; i < limit && !gate; i++) @(negedge clk);
    while (gate && width < 1000) begin
      width++;
      @(negedge clk);
    end
    readyAtFall = rdData[7];
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    finishRun();
  end

  initial begin
    int w;
    bit rdy;
    int pulses;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rdData == 8'h00, "R1", rdData, 8'h00);
    check(gate == 1'b0 && timerSelGate == 1'b0 && oscStopReq == 1'b0, "R1",
          {gate, timerSelGate, oscStopReq}, 0);
    check(fcCode == 3'b000, "R1", fcCode, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 / R3 register vectors
    for (int i = 0; i < 8; i++) begin
      regWrite(VEC[i][15:8]);
      check(rdData == VEC[i][7:0], "R2", rdData, VEC[i][7:0]);
      check(fcCode == VEC[i][2:0], "R3", fcCode, VEC[i][2:0]);
      check(timerSelGate == VEC[i][3], "R3", timerSelGate, VEC[i][3]);
    end

    // R4 stop request
    regWrite(8'h08);
    testPin = 1'b0; @(negedge clk);
    check(oscStopReq == 1'b0, "R4", oscStopReq, 0);
    testPin = 1'b1; @(negedge clk);
    check(oscStopReq == 1'b1, "R4", oscStopReq, 1);
    regWrite(8'h00);
    check(oscStopReq == 1'b0, "R4", oscStopReq, 0);
    testPin = 1'b0;

    // R5 / R6 measurement
    regWrite(8'h18);
    measure(200, w, rdy);
    check(w >= 37 && w <= 38, "R5", w, 37);
    check(rdy == 1'b1, "R6", rdy, 1);

    // R9 no new pulse while start stays set, even when rewritten
    regWrite(8'h18);
    pulses = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (gate) pulses++;
    end
    check(pulses == 0, "R9", pulses, 0);

    // R7 clear blocked while start bit stored
    regWrite(8'h10);
    check(rdData[7] == 1'b1, "R7", rdData[7], 1);
    regWrite(8'h00);
    check(rdData[7] == 1'b1, "R7", rdData[7], 1);

    // R8 clear when start bit already 0; writing 1 never sets
    regWrite(8'h00);
    check(rdData[7] == 1'b0, "R8", rdData[7], 0);
    regWrite(8'h80);
    check(rdData[7] == 1'b0, "R8", rdData[7], 0);
    check(rdData == 8'h00, "R8", rdData, 8'h00);

    // R9 restart after clear
    regWrite(8'h10);
    measure(200, w, rdy);
    check(w >= 37 && w <= 38, "R9", w, 37);
    check(rdy == 1'b1, "R6", rdy, 1);

    finishRun();
  end
endmodule